// File: doc/BRIEF.md
# Sticky Reset Cause Register

This block records why the system was last reset, or woken from its off state, and keeps that record through every reset except a power-on clear. Eight cause inputs arrive as single-cycle pulses: four system reset sources (external reset pin, watchdog expiry, software-requested reset, processor lock-up) and four wake-from-off sources (GPIO detect, analog comparator detect, debug interface entry, NFC field detect). Each pulse sets its own sticky bit. Bits accumulate across any number of resets until software clears them.

Software sees the bits as one 32-bit word on a simple register bus at a fixed offset. It clears bits by writing ones to them (write-one-to-clear), usually by writing all ones after reading. Separately, a fixed priority encoder condenses the sticky bits into one 4-bit cause code, so boot firmware can branch on a single dominant reason without decoding the word.

Top module: `rst_cause_keeper`

## Requirements
- R1: A pulse on src_pulse[0], [1], [2] or [3] (pin, watchdog, soft, lock-up) sets word bit 0, 1, 2 or 3 respectively, visible from the cycle after the pulse edge.
- R2: A pulse on src_pulse[4], [5], [6] or [7] (GPIO wake, comparator wake, debug wake, NFC wake) sets word bit 16, 17, 18 or 19 respectively.
- R3: Set bits stay set and accumulate across later pulses; a bit is never set without its pulse.
- R4: A bus write (bus_sel=1, bus_wr=1) at byte address 0x400 clears each recorded bit whose wdata bit is 1; bits written with 0 keep their value; writing 0xFFFFFFFF clears all.
- R5: When a cause pulse and a clearing write of its bit fall in the same cycle, the bit ends up set.
- R6: Word bits 4 to 15 and 20 to 31 always read 0, and writing ones to them changes nothing.
- R7: Writes to any other address, or with bus_sel=0, change nothing; a read (bus_sel=1, bus_wr=0) returns the word only at 0x400 and returns 0 otherwise.
- R8: With at least one bit set, cause_code is the index of the lowest-ordered set cause: 0 pin, 1 watchdog, 2 soft, 3 lock-up, 4 GPIO wake, 5 comparator wake, 6 debug wake, 7 NFC wake.
- R9: With no bit set, cause_code is 8 (hard reset).
- R10: por_clr high at a clock edge zeroes every bit, even if cause pulses arrive in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_clr | input | 1 | Synchronous active-high power-on clear |
| src_pulse | input | 8 | One-cycle cause pulses, index order pin, watchdog, soft, lock-up, GPIO wake, comparator wake, debug wake, NFC wake |
| bus_sel | input | 1 | Bus access select |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 32 | Write data (ones clear bits) |
| bus_rdata | output | 32 | Read data, combinational |
| cause_code | output | 4 | Prioritized cause, 0..7 or 8 for hard reset |

## Verification
The hardest situation to reach is a cause pulse landing in the very cycle a clearing write of the same bit is presented, since in a system the two come from unrelated agents. The bench drives both on the same falling edge after first setting a neighbouring bit, so one edge shows both the cleared neighbour and the surviving bit. The same trick puts por_clr against a full set of pulses, and the priority encoder is walked by building up bit patterns from the highest-ordered cause downward while reading the code after each step.

// File: rtl/rcause_pkg.sv
package rcause_pkg;

    localparam int SRC_N   = 8;   // number of cause sources
    localparam int LO_N    = 4;   // sources mapped to the low bits
    localparam int HI_BASE = 16;  // word bit of the first wake source
    localparam int WORD_W  = 32;
    localparam int ADDR_W  = 12;
    localparam int CODE_W  = 4;

    typedef enum logic [CODE_W-1:0] {
        CAUSE_PIN       = 4'd0,
        CAUSE_WDOG      = 4'd1,
        CAUSE_SOFT      = 4'd2,
        CAUSE_LOCKUP    = 4'd3,
        CAUSE_WAKE_GPIO = 4'd4,
        CAUSE_WAKE_CMP  = 4'd5,
        CAUSE_WAKE_DBG  = 4'd6,
        CAUSE_WAKE_NFC  = 4'd7,
        CAUSE_HARD      = 4'd8
    } cause_e;

    typedef struct packed {
        logic              sel;
        logic              wr;
        logic [ADDR_W-1:0] addr;
        logic [WORD_W-1:0] wdata;
    } bus_req_t;

    // word bit that holds source idx
    function automatic int bit_pos(input int idx);
        return (idx < LO_N) ? idx : (HI_BASE + idx - LO_N);
    endfunction

    function automatic logic [WORD_W-1:0] spread(input logic [SRC_N-1:0] s);
        logic [WORD_W-1:0] w;
        w = '0;
        for (int i = 0; i < SRC_N; i++) w[bit_pos(i)] = s[i];
        return w;
    endfunction

    function automatic logic [SRC_N-1:0] gather(input logic [WORD_W-1:0] w);
        logic [SRC_N-1:0] s;
        for (int i = 0; i < SRC_N; i++) s[i] = w[bit_pos(i)];
        return s;
    endfunction

    function automatic logic [WORD_W-1:0] used_mask();
        return spread({SRC_N{1'b1}});
    endfunction

endpackage

// File: rtl/rcause_latch.sv
module rcause_latch
    import rcause_pkg::*;
(
    input  logic             clk,
    input  logic             por_clr,
    input  logic [SRC_N-1:0] set_i,
    input  logic [SRC_N-1:0] clr_i,
    output logic [SRC_N-1:0] q_o
);

    // one sticky cell per source: power-on clear, then set, then clear
    for (genvar g = 0; g < SRC_N; g++) begin : g_cell
        always_ff @(posedge clk) begin
            if (por_clr)
                q_o[g] <= 1'b0;
            else if (set_i[g])
                q_o[g] <= 1'b1;
            else if (clr_i[g])
                q_o[g] <= 1'b0;
        end
    end

endmodule

// File: rtl/rcause_prio.sv
module rcause_prio
    import rcause_pkg::*;
(
    input  logic [SRC_N-1:0] sticky_i,
    output cause_e           code_o
);

    // scan downward so the lowest-ordered set source wins
    always_comb begin
        code_o = CAUSE_HARD;
        for (int i = SRC_N - 1; i >= 0; i--) begin
            if (sticky_i[i]) code_o = cause_e'(i[CODE_W-1:0]);
        end
    end

endmodule

// File: rtl/rcause_bus.sv
module rcause_bus
    import rcause_pkg::*;
#(
    parameter logic [ADDR_W-1:0] REG_OFFSET = 12'h400
) (
    input  bus_req_t          req_i,
    input  logic [WORD_W-1:0] word_i,
    output logic [SRC_N-1:0]  clr_o,
    output logic [WORD_W-1:0] rdata_o
);

    logic hit;
    assign hit = req_i.sel && (req_i.addr == REG_OFFSET);

    always_comb begin
        clr_o   = '0;
        rdata_o = '0;
        if (hit && req_i.wr)
            clr_o = gather(req_i.wdata);
        if (hit && !req_i.wr)
            rdata_o = word_i & used_mask();
    end

endmodule

// File: rtl/rst_cause_keeper.sv
module rst_cause_keeper
    import rcause_pkg::*;
#(
    parameter logic [ADDR_W-1:0] REG_OFFSET = 12'h400
) (
    input  logic              clk,
    input  logic              por_clr,
    input  logic [SRC_N-1:0]  src_pulse,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    output logic [CODE_W-1:0] cause_code
);

    bus_req_t          req;
    logic [SRC_N-1:0]  clr_mask;
    logic [SRC_N-1:0]  sticky;
    logic [WORD_W-1:0] cause_word;
    cause_e            code;

    assign req = '{sel: bus_sel, wr: bus_wr, addr: bus_addr, wdata: bus_wdata};

    rcause_bus #(.REG_OFFSET(REG_OFFSET)) bus_i (
        .req_i   (req),
        .word_i  (cause_word),
        .clr_o   (clr_mask),
        .rdata_o (bus_rdata)
    );

    rcause_latch latch_i (
        .clk     (clk),
        .por_clr (por_clr),
        .set_i   (src_pulse),
        .clr_i   (clr_mask),
        .q_o     (sticky)
    );

    rcause_prio prio_i (
        .sticky_i (sticky),
        .code_o   (code)
    );

    assign cause_word = spread(sticky);
    assign cause_code = code;

endmodule

// File: rtl/rcause_chk.sv
module rcause_chk
    import rcause_pkg::*;
(
    input logic              clk,
    input logic              por_clr,
    input logic [SRC_N-1:0]  src_pulse,
    input logic [WORD_W-1:0] word,
    input logic [CODE_W-1:0] cause_code
);

    // R1 R2
    set_bit_chk: assert property (@(posedge clk) disable iff (por_clr)
        (src_pulse != '0) |=>
        ((word & $past(spread(src_pulse))) == $past(spread(src_pulse))));

    // R3
    no_spurious_chk: assert property (@(posedge clk) disable iff (por_clr)
        1'b1 |=> ((word & ~$past(word) & ~$past(spread(src_pulse))) == '0));

    // R6
    unused_zero_chk: assert property (@(posedge clk) disable iff (por_clr)
        ((word & ~used_mask()) == '0));

    // R9
    hard_code_chk: assert property (@(posedge clk) disable iff (por_clr)
        (word == '0) |-> (cause_code == CAUSE_HARD));

    // R8
    prio_code_chk: assert property (@(posedge clk) disable iff (por_clr)
        (word != '0) |-> ((cause_code < CODE_W'(SRC_N)) &&
                          word[bit_pos(int'(cause_code))]));

    // R10
    por_zero_chk: assert property (@(posedge clk)
        por_clr |=> (word == '0));

endmodule

bind rst_cause_keeper rcause_chk chk_i (
    .clk        (clk),
    .por_clr    (por_clr),
    .src_pulse  (src_pulse),
    .word       (cause_word),
    .cause_code (cause_code)
);

// File: tb/rst_cause_keeper_tb.sv
module rst_cause_keeper_tb_top;

    logic        clk = 1'b0;
    logic        por_clr = 1'b1;
    logic [7:0]  src_pulse = '0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [3:0]  cause_code;

    int checks = 0;
    int errors = 0;
    logic [7:0] model = '0;

    always #10 clk = ~clk;

    rst_cause_keeper dut_i (
        .clk(clk), .por_clr(por_clr), .src_pulse(src_pulse),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cause_code(cause_code)
    );

    function automatic logic [31:0] exp_word(input logic [7:0] m);
        logic [31:0] w = '0;
        for (int i = 0; i < 4; i++) w[i] = m[i];
        for (int i = 4; i < 8; i++) w[i + 12] = m[i];
        return w;
    endfunction

    function automatic logic [3:0] exp_code(input logic [7:0] m);
        for (int i = 0; i < 8; i++) if (m[i]) return 4'(i);
        return 4'd8;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] v);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 v = bus_rdata;
        bus_sel = 1'b0;
    endtask

    // inputs driven at the falling edge, effect visible at the next falling edge
    task automatic cycle(input logic [7:0] p, input logic sel, input logic [11:0] a,
                         input logic [31:0] d, input logic por);
        @(negedge clk);
        src_pulse = p; bus_sel = sel; bus_wr = sel; bus_addr = a; bus_wdata = d; por_clr = por;
        @(negedge clk);
        src_pulse = '0; bus_sel = 1'b0; bus_wr = 1'b0; por_clr = 1'b0;
    endtask

    task automatic check_state(input string req);
        logic [31:0] v;
        rd(12'h400, v);
        check(req, v, exp_word(model));
        check(req, 32'(cause_code), 32'(exp_code(model)));
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        por_clr = 1'b0;
        model = '0;
        check_state("R9 R10 reset");
    endtask

    task automatic t_low_bits();
        for (int i = 0; i < 4; i++) begin
            cycle(8'(1 << i), 1'b0, 12'h0, 32'h0, 1'b0);
            model = 8'(1 << i);
            check_state("R1 low source");
            cycle(8'h00, 1'b1, 12'h400, 32'hFFFF_FFFF, 1'b0);
            model = '0;
        end
    endtask

    task automatic t_high_bits();
        for (int i = 4; i < 8; i++) begin
            cycle(8'(1 << i), 1'b0, 12'h0, 32'h0, 1'b0);
            model = 8'(1 << i);
            check_state("R2 wake source");
            cycle(8'h00, 1'b1, 12'h400, 32'hFFFF_FFFF, 1'b0);
            model = '0;
        end
        check_state("R4 clear all");
    endtask

    task automatic t_accumulate();
        cycle(8'h20, 1'b0, 12'h0, 32'h0, 1'b0);
        cycle(8'h02, 1'b0, 12'h0, 32'h0, 1'b0);
        repeat (5) @(negedge clk);
        model = 8'h22;
        check_state("R3 accumulate");
    endtask

    task automatic t_partial_clear();
        // clear word bit 17 only; bit 1 stays
        cycle(8'h00, 1'b1, 12'h400, 32'h0002_0000, 1'b0);
        model = 8'h02;
        check_state("R4 partial clear");
    endtask

    task automatic t_collision();
        cycle(8'h01, 1'b0, 12'h0, 32'h0, 1'b0);
        model = 8'h03;
        // clear all while source 1 pulses again
        cycle(8'h02, 1'b1, 12'h400, 32'hFFFF_FFFF, 1'b0);
        model = 8'h02;
        check_state("R5 pulse beats clear");
    endtask

    task automatic t_unused();
        cycle(8'h00, 1'b1, 12'h400, 32'hFFF0_FFF0, 1'b0);
        check_state("R6 unused write");
    endtask

    task automatic t_other_addr();
        logic [31:0] v;
        cycle(8'h00, 1'b1, 12'h404, 32'hFFFF_FFFF, 1'b0);
        check_state("R7 other address write");
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b1; bus_addr = 12'h400; bus_wdata = 32'hFFFF_FFFF;
        @(negedge clk);
        bus_wr = 1'b0;
        check_state("R7 unselected write");
        rd(12'h404, v);
        check("R7 other address read", v, 32'h0);
    endtask

    task automatic t_priority();
        cycle(8'h00, 1'b1, 12'h400, 32'hFFFF_FFFF, 1'b0);
        model = '0;
        for (int i = 7; i >= 0; i--) begin
            cycle(8'(1 << i), 1'b0, 12'h0, 32'h0, 1'b0);
            model[i] = 1'b1;
            check("R8 priority code", 32'(cause_code), 32'(exp_code(model)));
        end
        // peel off from the lowest upward
        for (int i = 0; i < 8; i++) begin
            cycle(8'h00, 1'b1, 12'h400, exp_word(8'(1 << i)), 1'b0);
            model[i] = 1'b0;
            check("R8 R9 code after clear", 32'(cause_code), 32'(exp_code(model)));
        end
    endtask

    task automatic t_por();
        cycle(8'h81, 1'b0, 12'h0, 32'h0, 1'b0);
        cycle(8'hFF, 1'b0, 12'h0, 32'h0, 1'b1);
        model = '0;
        check_state("R10 por beats pulses");
    endtask

    initial begin
        fork
            begin
                t_reset();
                t_low_bits();
                t_high_bits();
                t_accumulate();
                t_partial_clear();
                t_collision();
                t_unused();
                t_other_addr();
                t_priority();
                t_por();
            end
            begin
                repeat (100000) @(posedge clk);
                errors++;
                $display("FAIL watchdog actual timeout expected completion");
            end
        join_any
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule